// File: doc/BRIEF.md
# Precise Trap Commit Controller

This block is the exception and interrupt control for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Every instruction carries a token down the pipe with a fault flag and a two-bit reason code. Faults are seen at different times: an instruction-translation miss appears at fetch, an arithmetic fault appears in execute, and a data-translation miss appears in the memory stage. None of them acts at the moment it is detected. The block waits until the faulting token reaches the end of the memory stage. Tokens arrive there in program order, so the trap that is taken always belongs to the oldest faulting instruction.

When a trap is taken, the controller does four things. It suppresses the faulting instruction's store and register write. It turns everything in fetch, decode and execute into bubbles. It records a two-PC restart point, so that a fault in a branch delay slot can be resumed correctly. One cycle later it steers fetch to a fixed handler vector and raises supervisor mode. An external interrupt request is latched as pending. While the core runs in user mode, the next fetched instruction is replaced by a marked bubble, and the interrupt is taken when that bubble reaches the commit point. If an older fault flushes the bubble, the request stays pending and is injected again later.

The datapath, caches and translation units are not part of the block; they appear only as per-stage fault inputs. The pipeline never stalls: every stage accepts a new token each cycle, so there is no back-pressure at any pin. A fetch slot with `if_valid` low becomes a bubble.

Top module: `precise_trap_ctrl`

## Requirements
- R1: A token with no fault passes through with no delay. An instruction presented at fetch in cycle n drives `mem_store_o` in cycle n+3 if it is a store, and drives `wb_write_o` in cycle n+4 if it writes a register. `mem_pc_o` and `wb_pc_o` carry its PC in those cycles.
- R2: When the token in the memory stage carries a fault, the following are suppressed in that cycle: its store, its later register write, and any write by the tokens in fetch, decode and execute, which all become bubbles. Older instructions still complete their writes.
- R3: Only the oldest faulting instruction is reported. A younger instruction that faulted earlier in time, such as a fetch-translation miss behind an arithmetic fault, causes no second trap.
- R4: `cause_o` encodes the reason as 0 for interrupt, 1 for arithmetic, 2 for instruction translation and 3 for data translation. When one instruction faults in several stages, the code from the earliest stage is kept.
- R5: A pulse on `irq_req` is latched as pending. The next valid fetch slot in user mode is replaced by a marked bubble that never writes. The trap it raises reports cause 0 with `epc0_o` equal to the replaced PC.
- R6: If the marked bubble is squashed by an older trap, the request stays pending. It is injected again once the core is back in user mode.
- R7: The restart pair is <PC, PC+4> for an ordinary instruction. For the delay slot it is <slot PC, branch target> when the branch was taken, and <slot PC, slot PC+4> when it was not. The delay slot is the token that enters execute directly behind a branch that is in execute.
- R8: `redirect_o` pulses in the cycle after the trap cycle, with `redirect_pc_o` equal to the VEC_PC parameter. `sup_mode_o` rises in that same cycle. `cause_o`, `epc0_o` and `epc1_o` hold their values until the next trap.
- R9: A pulse on `trap_ret` returns to user mode on the next cycle. No interrupt bubble is injected while `sup_mode_o` is high.
- R10: After reset, the block is in user mode, nothing is pending, and every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_valid | input | 1 | A fetched instruction is present this cycle |
| if_pc | input | PC_W | PC of the fetched instruction |
| if_store | input | 1 | Fetched instruction writes memory |
| if_rdw | input | 1 | Fetched instruction writes a register |
| if_branch | input | 1 | Fetched instruction is a delayed branch |
| if_itlb_fault | input | 1 | Instruction translation miss on this fetch |
| ex_arith_fault | input | 1 | Arithmetic fault for the token in execute |
| ex_br_taken | input | 1 | Branch in execute is taken |
| ex_br_target | input | PC_W | Target of the branch in execute |
| mem_dtlb_fault | input | 1 | Data translation miss for the token in memory stage |
| irq_req | input | 1 | External interrupt request pulse |
| trap_ret | input | 1 | Return from handler to user mode |
| mem_store_o | output | 1 | Store of the memory-stage token is committed |
| mem_pc_o | output | PC_W | PC of the memory-stage token |
| wb_write_o | output | 1 | Register write of the writeback token is committed |
| wb_pc_o | output | PC_W | PC of the writeback token |
| redirect_o | output | 1 | Fetch must restart at the handler vector |
| redirect_pc_o | output | PC_W | Handler vector PC |
| cause_o | output | 2 | Reason code of the last trap |
| epc0_o | output | PC_W | First restart PC of the last trap |
| epc1_o | output | PC_W | Second restart PC of the last trap |
| sup_mode_o | output | 1 | Supervisor mode |

## Verification
Four properties are checked on every cycle. At most one marked interrupt bubble is in flight. A trap leaves decode, execute and memory empty on the next cycle and blocks the next writeback. The redirect and supervisor mode follow the trap by exactly one cycle. A delay-slot token in execute always has its branch directly ahead of it. Other properties depend on the history of a whole instruction stream, and only the bench scenarios show them. These are the choice of the oldest fault, keeping the first reason code, the restart pair for taken and untaken slots, and a pending interrupt that survives a flush and returns after the handler exits.

// File: rtl/ptc_pkg.sv
`timescale 1ns/1ps
package ptc_pkg;
  parameter int PC_W = 32;

  typedef enum logic [1:0] {
    CAUSE_IRQ   = 2'd0,
    CAUSE_ARITH = 2'd1,
    CAUSE_ITLB  = 2'd2,
    CAUSE_DTLB  = 2'd3
  } cause_e;

  typedef struct packed {
    logic            valid;
    logic [PC_W-1:0] pc;
    logic            store;
    logic            rdw;
    logic            branch;
    logic            exc;
    cause_e          cause;
    logic            intr;
    logic            slot;
    logic            taken;
    logic [PC_W-1:0] target;
  } tok_t;
endpackage

// File: rtl/ptc_irq_inject.sv
`timescale 1ns/1ps
module ptc_irq_inject (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic take_intr,
  input  logic intr_inflight,
  input  logic sup_mode,
  input  logic fetch_valid,
  input  logic flush,
  output logic inject_o
);
  logic pending_q;

  // a new request wins over the clear so no edge is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b0;
    else        pending_q <= irq_req | (pending_q & ~take_intr);
  end

  assign inject_o = pending_q & ~intr_inflight & ~sup_mode & fetch_valid & ~flush;
endmodule

// File: rtl/ptc_commit.sv
`timescale 1ns/1ps
module ptc_commit
  import ptc_pkg::*;
#(
  parameter logic [PC_W-1:0] VEC_PC = 32'h0000_0080
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            m_valid,
  input  logic            m_exc,
  input  cause_e          m_cause,
  input  logic [PC_W-1:0] m_pc,
  input  logic            m_slot,
  input  logic            m_taken,
  input  logic [PC_W-1:0] m_target,
  input  logic            dtlb_fault,
  input  logic            trap_ret,
  output logic            trap_o,
  output logic            take_intr_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic [1:0]      cause_o,
  output logic [PC_W-1:0] epc0_o,
  output logic [PC_W-1:0] epc1_o,
  output logic            sup_o
);
  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

  cause_e          cause_now;
  logic [PC_W-1:0] next_pc;
  logic            redirect_q, sup_q;
  cause_e          cause_q;
  logic [PC_W-1:0] epc0_q, epc1_q;

  assign trap_o      = m_valid & (m_exc | dtlb_fault);
  assign cause_now   = m_exc ? m_cause : CAUSE_DTLB;
  assign take_intr_o = trap_o & (cause_now == CAUSE_IRQ);
  assign next_pc     = (m_slot && m_taken) ? m_target : (m_pc + INSN_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_q <= 1'b0;
      sup_q      <= 1'b0;
      cause_q    <= CAUSE_IRQ;
      epc0_q     <= '0;
      epc1_q     <= '0;
    end else begin
      redirect_q <= trap_o;
      if (trap_o) begin
        sup_q   <= 1'b1;
        cause_q <= cause_now;
        epc0_q  <= m_pc;
        epc1_q  <= next_pc;
      end else if (trap_ret) begin
        sup_q <= 1'b0;
      end
    end
  end

  assign redirect_o    = redirect_q;
  assign redirect_pc_o = redirect_q ? VEC_PC : '0;
  assign cause_o       = cause_q;
  assign epc0_o        = epc0_q;
  assign epc1_o        = epc1_q;
  assign sup_o         = sup_q;

  AST_REDIRECT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |=> (redirect_o && sup_o)); // R8
  AST_RET_USER: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_ret && !trap_o) |=> !sup_o); // R9
endmodule

// File: rtl/precise_trap_ctrl.sv
`timescale 1ns/1ps
module precise_trap_ctrl
  import ptc_pkg::*;
#(
  parameter logic [PC_W-1:0] VEC_PC = 32'h0000_0080
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            if_valid,
  input  logic [PC_W-1:0] if_pc,
  input  logic            if_store,
  input  logic            if_rdw,
  input  logic            if_branch,
  input  logic            if_itlb_fault,
  input  logic            ex_arith_fault,
  input  logic            ex_br_taken,
  input  logic [PC_W-1:0] ex_br_target,
  input  logic            mem_dtlb_fault,
  input  logic            irq_req,
  input  logic            trap_ret,
  output logic            mem_store_o,
  output logic [PC_W-1:0] mem_pc_o,
  output logic            wb_write_o,
  output logic [PC_W-1:0] wb_pc_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic [1:0]      cause_o,
  output logic [PC_W-1:0] epc0_o,
  output logic [PC_W-1:0] epc1_o,
  output logic            sup_mode_o
);
  tok_t            id_q, ex_q, mem_q;
  tok_t            id_d, ex_d, mem_d;
  logic            wb_valid_q, wb_rdw_q;
  logic [PC_W-1:0] wb_pc_q;
  logic            trap_now, take_intr, inject, intr_inflight, sup;

  assign intr_inflight = (id_q.valid & id_q.intr) | (ex_q.valid & ex_q.intr)
                       | (mem_q.valid & mem_q.intr);

  // fetch -> decode: fault tag from fetch, or interrupt bubble in its place
  always_comb begin
    id_d = '0;
    if (!trap_now && if_valid) begin
      id_d.valid = 1'b1;
      id_d.pc    = if_pc;
      if (inject) begin
        id_d.exc   = 1'b1;
        id_d.cause = CAUSE_IRQ;
        id_d.intr  = 1'b1;
      end else begin
        id_d.store  = if_store;
        id_d.rdw    = if_rdw;
        id_d.branch = if_branch;
        if (if_itlb_fault) begin
          id_d.exc   = 1'b1;
          id_d.cause = CAUSE_ITLB;
        end
      end
    end
  end

  // decode -> execute: the token behind a branch in execute is its delay slot
  always_comb begin
    ex_d = '0;
    if (!trap_now && id_q.valid) begin
      ex_d = id_q;
      if (ex_q.valid && ex_q.branch) begin
        ex_d.slot   = 1'b1;
        ex_d.taken  = ex_br_taken;
        ex_d.target = ex_br_target;
      end
    end
  end

  // execute -> memory: the earliest tag already carried is kept
  always_comb begin
    mem_d = '0;
    if (!trap_now && ex_q.valid) begin
      mem_d = ex_q;
      if (!ex_q.exc && ex_arith_fault) begin
        mem_d.exc   = 1'b1;
        mem_d.cause = CAUSE_ARITH;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q       <= '0;
      ex_q       <= '0;
      mem_q      <= '0;
      wb_valid_q <= 1'b0;
      wb_rdw_q   <= 1'b0;
      wb_pc_q    <= '0;
    end else begin
      id_q       <= id_d;
      ex_q       <= ex_d;
      mem_q      <= mem_d;
      wb_valid_q <= mem_q.valid & ~trap_now;
      wb_rdw_q   <= mem_q.rdw;
      wb_pc_q    <= mem_q.pc;
    end
  end

  ptc_irq_inject u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_req      (irq_req),
    .take_intr    (take_intr),
    .intr_inflight(intr_inflight),
    .sup_mode     (sup),
    .fetch_valid  (if_valid),
    .flush        (trap_now),
    .inject_o     (inject)
  );

  ptc_commit #(.VEC_PC(VEC_PC)) u_commit (
    .clk          (clk),
    .rst_n        (rst_n),
    .m_valid      (mem_q.valid),
    .m_exc        (mem_q.exc),
    .m_cause      (mem_q.cause),
    .m_pc         (mem_q.pc),
    .m_slot       (mem_q.slot),
    .m_taken      (mem_q.taken),
    .m_target     (mem_q.target),
    .dtlb_fault   (mem_dtlb_fault),
    .trap_ret     (trap_ret),
    .trap_o       (trap_now),
    .take_intr_o  (take_intr),
    .redirect_o   (redirect_o),
    .redirect_pc_o(redirect_pc_o),
    .cause_o      (cause_o),
    .epc0_o       (epc0_o),
    .epc1_o       (epc1_o),
    .sup_o        (sup)
  );

  assign mem_store_o = mem_q.valid & mem_q.store & ~trap_now;
  assign mem_pc_o    = mem_q.pc;
  assign wb_write_o  = wb_valid_q & wb_rdw_q;
  assign wb_pc_o     = wb_pc_q;
  assign sup_mode_o  = sup;

  AST_INTR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({id_q.valid & id_q.intr, ex_q.valid & ex_q.intr, mem_q.valid & mem_q.intr}) <= 1); // R5
  AST_SQUASH_YOUNG: assert property (@(posedge clk) disable iff (!rst_n)
    trap_now |=> !(id_q.valid || ex_q.valid || mem_q.valid)); // R2
  AST_NO_WB_FAULTER: assert property (@(posedge clk) disable iff (!rst_n)
    trap_now |=> !wb_write_o); // R2
  AST_SLOT_AFTER_BR: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_q.valid && ex_q.slot) |-> (mem_q.valid && mem_q.branch)); // R7
endmodule

// File: tb/precise_trap_ctrl_tb.sv
`timescale 1ns/1ps
module precise_trap_ctrl_tb;
  import ptc_pkg::*;

  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] TGT  = 32'h0000_2000;
  localparam logic [31:0] VEC  = 32'h0000_0080;

  logic clk = 1'b0;
  logic rst_n;
  logic if_valid, if_store, if_rdw, if_branch, if_itlb_fault;
  logic [31:0] if_pc, ex_br_target;
  logic ex_arith_fault, ex_br_taken, mem_dtlb_fault, irq_req, trap_ret;
  logic mem_store_o, wb_write_o, redirect_o, sup_mode_o;
  logic [31:0] mem_pc_o, wb_pc_o, redirect_pc_o, epc0_o, epc1_o;
  logic [1:0] cause_o;

  always #2.5 clk = ~clk;

  precise_trap_ctrl #(.VEC_PC(VEC)) u_dut (
    .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_pc(if_pc),
    .if_store(if_store), .if_rdw(if_rdw), .if_branch(if_branch),
    .if_itlb_fault(if_itlb_fault), .ex_arith_fault(ex_arith_fault),
    .ex_br_taken(ex_br_taken), .ex_br_target(ex_br_target),
    .mem_dtlb_fault(mem_dtlb_fault), .irq_req(irq_req), .trap_ret(trap_ret),
    .mem_store_o(mem_store_o), .mem_pc_o(mem_pc_o), .wb_write_o(wb_write_o),
    .wb_pc_o(wb_pc_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .cause_o(cause_o), .epc0_o(epc0_o), .epc1_o(epc1_o), .sup_mode_o(sup_mode_o)
  );

  int n_chk = 0, n_bad = 0;
  logic p_store[16], p_rdw[16], p_br[16], p_taken[16], p_itlb[16], p_arith[16], p_dtlb[16];
  int plen, ncyc, irq_cyc, ret_cyc, cur;
  logic running = 1'b0;
  int wb_cyc[16], st_cyc[16];
  int trap_n;
  int tr_cause[2], tr_cyc[2], tr_e0[2], tr_e1[2], tr_rpc[2], tr_sup[2];

  task automatic chk(input int act, input int exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int idx(input logic [31:0] pc);
    return int'((pc - BASE) >> 2);
  endfunction

  always @(negedge clk) begin
    if (running) begin
      if (wb_write_o && idx(wb_pc_o) >= 0 && idx(wb_pc_o) < 16) wb_cyc[idx(wb_pc_o)] = cur;
      if (mem_store_o && idx(mem_pc_o) >= 0 && idx(mem_pc_o) < 16) st_cyc[idx(mem_pc_o)] = cur;
      if (redirect_o) begin
        if (trap_n < 2) begin
          tr_cause[trap_n] = int'(cause_o);
          tr_cyc[trap_n]   = cur;
          tr_e0[trap_n]    = int'(epc0_o);
          tr_e1[trap_n]    = int'(epc1_o);
          tr_rpc[trap_n]   = int'(redirect_pc_o);
          tr_sup[trap_n]   = int'(sup_mode_o);
        end
        trap_n++;
      end
    end
  end

  task automatic idle_inputs();
    if_valid = 0; if_pc = 0; if_store = 0; if_rdw = 0; if_branch = 0; if_itlb_fault = 0;
    ex_arith_fault = 0; ex_br_taken = 0; ex_br_target = 0; mem_dtlb_fault = 0;
    irq_req = 0; trap_ret = 0;
  endtask

  task automatic reset_dut();
    idle_inputs();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic new_prog(input int len, input int cycles);
    plen = len; ncyc = cycles; irq_cyc = -1; ret_cyc = -1; trap_n = 0;
    for (int i = 0; i < 16; i++) begin
      p_store[i] = 0; p_rdw[i] = 1; p_br[i] = 0; p_taken[i] = 0;
      p_itlb[i] = 0; p_arith[i] = 0; p_dtlb[i] = 0;
      wb_cyc[i] = -1; st_cyc[i] = -1;
    end
  endtask

  task automatic run_prog();
    reset_dut();
    running = 1;
    for (int c = 0; c < ncyc; c++) begin
      cur = c;
      if_valid      = (c < plen);
      if_pc         = BASE + 32'(4 * c);
      if_store      = (c < plen) ? p_store[c] : 1'b0;
      if_rdw        = (c < plen) ? p_rdw[c] : 1'b0;
      if_branch     = (c < plen) ? p_br[c] : 1'b0;
      if_itlb_fault = (c < plen) ? p_itlb[c] : 1'b0;
      ex_arith_fault = (c >= 2 && c - 2 < plen) ? p_arith[c-2] : 1'b0;
      ex_br_taken    = (c >= 2 && c - 2 < plen) ? p_taken[c-2] : 1'b0;
      ex_br_target   = TGT;
      mem_dtlb_fault = (c >= 3 && c - 3 < plen) ? p_dtlb[c-3] : 1'b0;
      irq_req  = (c == irq_cyc);
      trap_ret = (c == ret_cyc);
      @(posedge clk); #1;
    end
    running = 0;
    idle_inputs();
  endtask

  task automatic t_reset();
    reset_dut();
    #1;
    chk(int'(sup_mode_o), 0, "R10", "supervisor after reset");
    chk(int'(redirect_o), 0, "R10", "redirect after reset");
    chk(int'(wb_write_o | mem_store_o), 0, "R10", "writes after reset");
    chk(int'(epc0_o), 0, "R10", "epc0 after reset");
  endtask

  task automatic t_clean();
    new_prog(6, 12);
    p_store[1] = 1; p_rdw[1] = 0;
    run_prog();
    chk(wb_cyc[0], 4, "R1", "first reg write cycle");
    chk(wb_cyc[5], 9, "R1", "last reg write cycle");
    chk(st_cyc[1], 4, "R1", "store commit cycle");
    chk(trap_n, 0, "R1", "no trap on clean stream");
  endtask

  task automatic t_arith();
    new_prog(8, 14);
    p_arith[2] = 1;
    run_prog();
    chk(trap_n, 1, "R2", "trap count");
    chk(tr_cause[0], 1, "R4", "arith cause");
    chk(tr_e0[0], int'(BASE + 8), "R7", "epc0 plain");
    chk(tr_e1[0], int'(BASE + 12), "R7", "epc1 plain");
    chk(tr_cyc[0], 6, "R8", "redirect cycle");
    chk(tr_rpc[0], int'(VEC), "R8", "vector pc");
    chk(tr_sup[0], 1, "R8", "supervisor with redirect");
    chk(wb_cyc[1], 5, "R2", "older instruction writes");
    for (int i = 2; i < 6; i++) chk(wb_cyc[i], -1, "R2", "faulting/younger write blocked");
    chk(wb_cyc[6], 10, "R2", "handler stream writes");
    trap_ret = 1; @(posedge clk); #1; trap_ret = 0;
    chk(int'(sup_mode_o), 0, "R9", "return to user mode");
  endtask

  task automatic t_order();
    new_prog(6, 12);
    p_arith[1] = 1; p_itlb[2] = 1;
    run_prog();
    chk(trap_n, 1, "R3", "only one trap");
    chk(tr_cause[0], 1, "R3", "oldest cause reported");
    chk(tr_e0[0], int'(BASE + 4), "R3", "oldest pc reported");
    chk(tr_cyc[0], 5, "R3", "trap cycle of older fault");
  endtask

  task automatic t_dtlb();
    new_prog(5, 11);
    p_store[0] = 1; p_store[1] = 1; p_dtlb[1] = 1;
    run_prog();
    chk(st_cyc[0], 3, "R2", "older store committed");
    chk(st_cyc[1], -1, "R2", "faulting store suppressed");
    chk(tr_cause[0], 3, "R4", "data translation cause");
    chk(tr_e0[0], int'(BASE + 4), "R2", "epc0 data fault");
  endtask

  task automatic t_multi();
    new_prog(5, 11);
    p_itlb[1] = 1; p_arith[1] = 1; p_dtlb[1] = 1;
    run_prog();
    chk(trap_n, 1, "R4", "one trap for multi-fault");
    chk(tr_cause[0], 2, "R4", "earliest stage cause kept");
  endtask

  task automatic t_irq();
    new_prog(10, 14);
    irq_cyc = 2;
    run_prog();
    chk(trap_n, 1, "R5", "interrupt trap count");
    chk(tr_cause[0], 0, "R5", "interrupt cause");
    chk(tr_e0[0], int'(BASE + 12), "R5", "replaced pc");
    chk(tr_e1[0], int'(BASE + 16), "R7", "interrupt epc1");
    chk(tr_cyc[0], 7, "R5", "interrupt redirect cycle");
    chk(wb_cyc[2], 6, "R5", "instruction before bubble writes");
    chk(wb_cyc[3], -1, "R5", "replaced slot never writes");
  endtask

  task automatic t_reinject();
    new_prog(14, 20);
    irq_cyc = 2; p_arith[2] = 1; ret_cyc = 8;
    run_prog();
    chk(trap_n, 2, "R6", "interrupt retaken after flush");
    chk(tr_cause[0], 1, "R6", "older fault taken first");
    chk(tr_e0[0], int'(BASE + 8), "R6", "first trap pc");
    chk(tr_cause[1], 0, "R6", "second trap is interrupt");
    chk(tr_e0[1], int'(BASE + 36), "R9", "injected only after return");
    chk(tr_cyc[1], 13, "R6", "second redirect cycle");
    chk(wb_cyc[8], 12, "R9", "no bubble while supervisor");
  endtask

  task automatic t_slot(input logic taken);
    new_prog(6, 12);
    p_br[1] = 1; p_taken[1] = taken; p_arith[2] = 1;
    run_prog();
    chk(tr_e0[0], int'(BASE + 8), "R7", "slot epc0");
    chk(tr_e1[0], taken ? int'(TGT) : int'(BASE + 12), "R7",
        taken ? "slot epc1 taken" : "slot epc1 not taken");
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    t_reset();
    t_clean();
    t_arith();
    t_order();
    t_dtlb();
    t_multi();
    t_irq();
    t_reinject();
    t_slot(1'b1);
    t_slot(1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule